// File: doc/BRIEF.md
# Prefix-suffix instruction combiner

This block sits in the first decode stage. It watches a stream of 32-bit instruction words, each with its fetch address and a valid flag. A word whose major opcode marks it as a prefix is not passed on. The block keeps it and joins it with the next valid word, the suffix. That word then leaves as one combined instruction.

For a combined instruction the block produces four things:
- a sign-extended immediate built from both words;
- a PC-relative select bit taken from the prefix;
- a verdict on whether the prefix type and subtype allow this suffix;
- the address of the prefix, rebuilt by overlaying saved prefix address bits onto the suffix address.

A plain word passes through with its own immediate and address. Two major opcodes exist only as suffixes, and they are flagged illegal when they arrive alone. A flush drops any held prefix.

Every result is registered and appears one cycle after the word that produced it. The downstream decode tables read the 7-bit instruction code. Its upper six bits are the major opcode and its low bit marks the prefixed variant.

Top module: `prefix_combiner`

## Requirements
- R1: While reset is high and in the first cycle after it, out_valid is 0 and no prefix is held.
- R2: A valid word with major opcode (bits 31:26) equal to 1, arriving while no prefix is held, is stored and produces no output in the following cycle.
- R3: Any other valid, unflushed word produces out_valid for exactly one cycle, one cycle after it is presented. With it come out_word equal to the word and out_code = {opcode, p}, where p is 1 if a prefix was held (the word is its suffix) and 0 otherwise.
- R4: out_imm is the 34-bit value {prefix bits 17:0, suffix bits 15:0}, sign-extended to XW bits, for a combined instruction. For a plain word it is bits 15:0, sign-extended.
- R5: out_pcrel equals prefix bit 20 for a combined instruction and 0 for a plain word.
- R6: out_addr for a combined instruction is the suffix address with bits 5:2 replaced by bits 5:2 of the prefix address. For a plain word it is the word's own address.
- R7: Prefix type is bits 25:24 and subtype is bit 23. out_sfx_ok is 1 for a plain word. For a combined instruction it is 1 only when the subtype is 0 and one of these holds: type 0 with suffix opcode 48..63; type 2 with suffix opcode 32..55 or 14; type 3 with any suffix. The verdict never changes out_code.
- R8: out_illegal is 1 for a plain word with opcode 57 or 61, and 0 for every combined instruction.
- R9: flush clears a held prefix and discards a word presented in the same cycle. The next word is decoded as a standalone word.
- R10: Cycles with in_valid low neither produce output nor release a held prefix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Drop held prefix and current word |
| in_valid | input | 1 | in_word/in_addr carry a word |
| in_word | input | 32 | Instruction word |
| in_addr | input | AW | Fetch address of in_word |
| out_valid | output | 1 | Output instruction present |
| out_word | output | 32 | Standalone word or suffix |
| out_code | output | 7 | {opcode, prefixed flag} |
| out_imm | output | XW | Sign-extended immediate |
| out_pcrel | output | 1 | PC-relative select |
| out_sfx_ok | output | 1 | Prefix type/subtype allows this suffix |
| out_illegal | output | 1 | Suffix-only opcode seen standalone |
| out_addr | output | AW | Instruction address (prefix address if combined) |

## Verification
The hardest case to reach is a held prefix that survives several cycles before its suffix arrives, including cases where that pairing is cut short. The stimulus places idle cycles between a prefix and its suffix, and asserts flush both while a prefix is held and in the very cycle a word is offered. It also presents a prefix immediately after another prefix, so the second one is consumed as a suffix. Prefix and suffix addresses are chosen so that the overlaid bits 5:2 differ from the suffix's own bits, which makes a missing overlay show up in the address check.

// File: rtl/pfxc_pkg.sv
package pfxc_pkg;
  localparam int WORD_W = 32;
  localparam int OPC_W  = 6;
  localparam int HI_W   = 18;
  localparam int LO_W   = 16;
  localparam int CODE_W = OPC_W + 1;
  localparam logic [OPC_W-1:0] OPC_PREFIX = 6'd1;
  localparam logic [OPC_W-1:0] OPC_SOLO_A = 6'd57;
  localparam logic [OPC_W-1:0] OPC_SOLO_B = 6'd61;

  typedef struct packed {
    logic [1:0]      kind;
    logic            sub;
    logic            pcrel;
    logic [HI_W-1:0] hi_imm;
  } pfx_fields_t;

  function automatic logic [OPC_W-1:0] major_op(input logic [WORD_W-1:0] w);
    return w[31:26];
  endfunction

  function automatic pfx_fields_t split_prefix(input logic [WORD_W-1:0] w);
    pfx_fields_t f;
    f.kind   = w[25:24];
    f.sub    = w[23];
    f.pcrel  = w[20];
    f.hi_imm = w[17:0];
    return f;
  endfunction
endpackage

// File: rtl/pfxc_hold.sv
module pfxc_hold
  import pfxc_pkg::*;
#(
  parameter int ALO = 2,
  parameter int AHI = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              in_valid,
  input  logic [OPC_W-1:0]  opcode,
  input  pfx_fields_t       fields,
  input  logic [AHI:ALO]    abits,
  output logic              pending,
  output pfx_fields_t       held,
  output logic [AHI:ALO]    held_abits,
  output logic              emit
);
  logic capture, consume;

  assign capture = in_valid && !flush && !pending && (opcode == OPC_PREFIX);
  assign consume = in_valid && !flush && pending;
  assign emit    = in_valid && !flush && !capture;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      pending <= 1'b0;
    end else if (capture) begin
      pending <= 1'b1;
    end else if (consume) begin
      pending <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held       <= '0;
      held_abits <= '0;
    end else if (capture) begin
      held       <= fields;
      held_abits <= abits;
    end
  end
endmodule

// File: rtl/pfxc_rules.sv
module pfxc_rules
  import pfxc_pkg::*;
(
  input  logic             prefixed,
  input  logic [OPC_W-1:0] opcode,
  input  logic [1:0]       kind,
  input  logic             sub,
  output logic             sfx_ok,
  output logic             illegal
);
  logic allowed;

  always_comb begin
    unique case (kind)
      2'b00:   allowed = !sub && (opcode[5:4] == 2'b11);
      2'b10:   allowed = !sub && ((opcode[5] && (opcode < 6'd56)) || (opcode == 6'd14));
      2'b11:   allowed = !sub;
      default: allowed = 1'b0;
    endcase
  end

  assign sfx_ok  = prefixed ? allowed : 1'b1;
  assign illegal = !prefixed && ((opcode == OPC_SOLO_A) || (opcode == OPC_SOLO_B));
endmodule

// File: rtl/pfxc_form.sv
module pfxc_form
  import pfxc_pkg::*;
#(
  parameter int AW  = 32,
  parameter int XW  = 64,
  parameter int ALO = 2,
  parameter int AHI = 5
) (
  input  logic             prefixed,
  input  logic [LO_W-1:0]  lo_imm,
  input  logic [HI_W-1:0]  hi_imm,
  input  logic             pfx_pcrel,
  input  logic [AW-1:0]    addr,
  input  logic [AHI:ALO]   pfx_abits,
  output logic [XW-1:0]    imm,
  output logic             pcrel,
  output logic [AW-1:0]    addr_o
);
  localparam int WIDE_W = HI_W + LO_W;

  logic [WIDE_W-1:0] wide;
  assign wide = {hi_imm, lo_imm};

  always_comb begin
    if (prefixed) imm = {{(XW-WIDE_W){wide[WIDE_W-1]}}, wide};
    else          imm = {{(XW-LO_W){lo_imm[LO_W-1]}}, lo_imm};
  end

  assign pcrel = prefixed && pfx_pcrel;

  always_comb begin
    addr_o = addr;
    if (prefixed) addr_o[AHI:ALO] = pfx_abits;
  end
endmodule

// File: rtl/prefix_combiner.sv
module prefix_combiner
  import pfxc_pkg::*;
#(
  parameter int AW  = 32,
  parameter int XW  = 64,
  parameter int ALO = 2,
  parameter int AHI = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              in_valid,
  input  logic [31:0]       in_word,
  input  logic [AW-1:0]     in_addr,
  output logic              out_valid,
  output logic [31:0]       out_word,
  output logic [6:0]        out_code,
  output logic [XW-1:0]     out_imm,
  output logic              out_pcrel,
  output logic              out_sfx_ok,
  output logic              out_illegal,
  output logic [AW-1:0]     out_addr
);
  logic [OPC_W-1:0] opcode;
  pfx_fields_t      fields, held;
  logic [AHI:ALO]   held_abits;
  logic             pending, emit;
  logic             nx_ok, nx_ill, nx_pcrel;
  logic [XW-1:0]    nx_imm;
  logic [AW-1:0]    nx_addr;

  assign opcode = major_op(in_word);
  assign fields = split_prefix(in_word);

  pfxc_hold #(.ALO(ALO), .AHI(AHI)) u_hold (
    .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid),
    .opcode(opcode), .fields(fields), .abits(in_addr[AHI:ALO]),
    .pending(pending), .held(held), .held_abits(held_abits), .emit(emit)
  );

  pfxc_rules u_rules (
    .prefixed(pending), .opcode(opcode), .kind(held.kind), .sub(held.sub),
    .sfx_ok(nx_ok), .illegal(nx_ill)
  );

  pfxc_form #(.AW(AW), .XW(XW), .ALO(ALO), .AHI(AHI)) u_form (
    .prefixed(pending), .lo_imm(in_word[15:0]), .hi_imm(held.hi_imm),
    .pfx_pcrel(held.pcrel), .addr(in_addr), .pfx_abits(held_abits),
    .imm(nx_imm), .pcrel(nx_pcrel), .addr_o(nx_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= emit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_word    <= '0;
      out_code    <= '0;
      out_imm     <= '0;
      out_pcrel   <= 1'b0;
      out_sfx_ok  <= 1'b0;
      out_illegal <= 1'b0;
      out_addr    <= '0;
    end else if (emit) begin
      out_word    <= in_word;
      out_code    <= {opcode, pending};
      out_imm     <= nx_imm;
      out_pcrel   <= nx_pcrel;
      out_sfx_ok  <= nx_ok;
      out_illegal <= nx_ill;
      out_addr    <= nx_addr;
    end
  end
endmodule

// File: rtl/prefix_combiner_chk.sv
module prefix_combiner_chk (
  input logic        clk,
  input logic        rst,
  input logic        flush,
  input logic        in_valid,
  input logic [31:0] in_word,
  input logic        pending,
  input logic        out_valid,
  input logic [6:0]  out_code,
  input logic        out_illegal
);
  AST_RESET_STATE: assert property (@(posedge clk) rst |=> !out_valid && !pending); // R1
  AST_PREFIX_QUIET: assert property (@(posedge clk) disable iff (rst)
    in_valid && !flush && !pending && in_word[31:26] == 6'd1 |=> !out_valid && pending); // R2
  AST_SUFFIX_OUT: assert property (@(posedge clk) disable iff (rst)
    in_valid && !flush && pending |=> out_valid && out_code[0] && !pending); // R3
  AST_PLAIN_OUT: assert property (@(posedge clk) disable iff (rst)
    in_valid && !flush && !pending && in_word[31:26] != 6'd1 |=> out_valid && !out_code[0]); // R3
  AST_NO_ILLEGAL_JOINED: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_code[0] |-> !out_illegal); // R8
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
    flush |=> !out_valid && !pending); // R9
  AST_GAP_KEEPS: assert property (@(posedge clk) disable iff (rst)
    !in_valid && !flush |=> !out_valid && pending == $past(pending)); // R10
endmodule

bind prefix_combiner prefix_combiner_chk u_chk (
  .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid), .in_word(in_word),
  .pending(pending), .out_valid(out_valid), .out_code(out_code),
  .out_illegal(out_illegal)
);

// File: tb/prefix_combiner_test.sv
module prefix_combiner_test;
  localparam int AW = 32;
  localparam int XW = 64;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, flush = 1'b0, in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic [AW-1:0] in_addr = '0;
  logic out_valid, out_pcrel, out_sfx_ok, out_illegal;
  logic [31:0] out_word;
  logic [6:0] out_code;
  logic [XW-1:0] out_imm;
  logic [AW-1:0] out_addr;

  prefix_combiner #(.AW(AW), .XW(XW)) uut (
    .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid), .in_word(in_word),
    .in_addr(in_addr), .out_valid(out_valid), .out_word(out_word), .out_code(out_code),
    .out_imm(out_imm), .out_pcrel(out_pcrel), .out_sfx_ok(out_sfx_ok),
    .out_illegal(out_illegal), .out_addr(out_addr)
  );

  typedef struct {
    logic [31:0] word; logic [6:0] code; logic [XW-1:0] imm;
    logic pcrel, ok, ill; logic [AW-1:0] addr; string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  bit m_held = 0;
  logic [31:0] m_pfx;
  logic [AW-1:0] m_paddr;

  task automatic chk(input bit good, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic bit rule_ok(input logic [1:0] k, input logic s, input logic [5:0] op);
    if (s) return 0;
    case (k)
      2'b00: return op >= 6'd48;
      2'b10: return (op >= 6'd32 && op <= 6'd55) || op == 6'd14;
      2'b11: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic send(input logic [31:0] w, input logic [AW-1:0] a, input bit v, input bit fl, input string tag);
    exp_t e;
    logic [33:0] w34;
    @(posedge clk); #1;
    in_word = w; in_addr = a; in_valid = v; flush = fl;
    if (fl) m_held = 0;
    else if (v) begin
      if (!m_held && w[31:26] == 6'd1) begin
        m_held = 1; m_pfx = w; m_paddr = a;
      end else begin
        e.word = w; e.tag = tag;
        e.code = {w[31:26], m_held};
        if (m_held) begin
          w34 = {m_pfx[17:0], w[15:0]};
          e.imm = {{(XW-34){w34[33]}}, w34};
          e.pcrel = m_pfx[20];
          e.ok = rule_ok(m_pfx[25:24], m_pfx[23], w[31:26]);
          e.ill = 0;
          e.addr = {a[AW-1:6], m_paddr[5:2], a[1:0]};
        end else begin
          e.imm = {{(XW-16){w[15]}}, w[15:0]};
          e.pcrel = 0; e.ok = 1;
          e.ill = (w[31:26] == 6'd57) || (w[31:26] == 6'd61);
          e.addr = a;
        end
        q.push_back(e);
        m_held = 0;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send('0, '0, 0, 0, "R10");
  endtask

  function automatic logic [31:0] pw(input logic [1:0] k, input logic s, input logic r, input logic [17:0] hi);
    return {6'd1, k, s, 2'b00, r, 2'b00, hi};
  endfunction

  function automatic logic [31:0] sw(input logic [5:0] op, input logic [15:0] lo);
    return {op, 10'h15a, lo};
  endfunction

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q.size() == 0) chk(0, "R2 unexpected output", 64'(out_word), 64'hx);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(out_code == e.code, {e.tag, " code"}, 64'(out_code), 64'(e.code));
        chk(out_word == e.word, "R3 word", 64'(out_word), 64'(e.word));
        chk(out_imm == e.imm, "R4 imm", out_imm, e.imm);
        chk(out_pcrel == e.pcrel, "R5 pcrel", 64'(out_pcrel), 64'(e.pcrel));
        chk(out_addr == e.addr, "R6 addr", 64'(out_addr), 64'(e.addr));
        chk(out_sfx_ok == e.ok, "R7 sfx_ok", 64'(out_sfx_ok), 64'(e.ok));
        chk(out_illegal == e.ill, "R8 illegal", 64'(out_illegal), 64'(e.ill));
      end
    end
  end

  bit done = 0;
  initial begin
    #(200000 * 4);
    if (!done) begin
      chk(0, "watchdog", 64'd0, 64'd1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) begin
      @(negedge clk);
      chk(out_valid == 0, "R1 out_valid in reset", 64'(out_valid), 64'd0);
    end
    @(posedge clk); #1; rst = 0;
    @(negedge clk);
    chk(out_valid == 0, "R1 out_valid after reset", 64'(out_valid), 64'd0);
    send(sw(6'd14, 16'h8001), 32'h1000, 1, 0, "R1");          // first word standalone
    send(sw(6'd14, 16'h7fff), 32'h1004, 1, 0, "R3");
    send(pw(2'b10, 0, 1, 18'h20001), 32'h2038, 1, 0, "R2");   // R2: prefix silent
    send(sw(6'd32, 16'h1234), 32'h203c, 1, 0, "R3");
    send(pw(2'b00, 0, 0, 18'h3ffff), 32'h3000, 1, 0, "R2");
    send(sw(6'd57, 16'hfff0), 32'h3044, 1, 0, "R6");          // overlay differs
    send(sw(6'd57, 16'h0004), 32'h3100, 1, 0, "R8");
    send(sw(6'd61, 16'h0008), 32'h3104, 1, 0, "R8");
    send(pw(2'b11, 0, 0, 18'h00000), 32'h3108, 1, 0, "R2");
    send(sw(6'd61, 16'h0010), 32'h310c, 1, 0, "R8");
    send(pw(2'b01, 0, 1, 18'h00aaa), 32'h4000, 1, 0, "R2");
    send(sw(6'd40, 16'h0001), 32'h4004, 1, 0, "R7");
    send(pw(2'b10, 1, 0, 18'h00555), 32'h4010, 1, 0, "R2");
    send(sw(6'd40, 16'h0002), 32'h4014, 1, 0, "R7");
    send(pw(2'b00, 0, 0, 18'h00001), 32'h4020, 1, 0, "R2");
    send(sw(6'd32, 16'h0003), 32'h4024, 1, 0, "R7");
    send(pw(2'b11, 0, 1, 18'h12345), 32'h4030, 1, 0, "R2");
    send(sw(6'd24, 16'h9abc), 32'h4034, 1, 0, "R7");
    send(pw(2'b10, 0, 0, 18'h00100), 32'h5008, 1, 0, "R2");
    idle(3);
    send(sw(6'd36, 16'h0040), 32'h500c, 1, 0, "R10");
    send(pw(2'b10, 0, 1, 18'h00777), 32'h6000, 1, 0, "R2");
    send('0, '0, 0, 1, "R9");
    send(sw(6'd57, 16'h0020), 32'h6004, 1, 0, "R9");         // standalone after flush
    send(pw(2'b10, 0, 1, 18'h00777), 32'h6010, 1, 0, "R2");
    send(sw(6'd32, 16'h0021), 32'h6014, 1, 1, "R9");         // dropped with flush
    send(sw(6'd33, 16'h0022), 32'h6018, 1, 0, "R9");
    send(pw(2'b11, 0, 0, 18'h00002), 32'h7000, 1, 0, "R2");
    send(pw(2'b10, 0, 1, 18'h00003), 32'h7004, 1, 0, "R3");   // second prefix is suffix
    send(sw(6'd14, 16'h0005), 32'h7008, 1, 0, "R3");
    idle(4);
    chk(q.size() == 0, "R3 outputs missing", 64'(q.size()), 64'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule